// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the 8-bit status byte of a serial NOR flash and answers the four commands that touch it. Commands arrive over a single-bit SPI target port (mode 0, SCK idles low). The block samples the chip select, clock and data lines in its own system clock domain through a synchronizer. A command decoder state machine collects the opcode and any data byte. It streams the status byte back on the output line, and it raises one-cycle request pulses when chip select rises. A second state machine owns the status byte. It applies write-enable requests, checks the write-protect pin and the enable bit before a status write, and then runs a self-timed write of a programmable length.

Erase and program sequencers elsewhere in the chip report through three inputs. While the busy input is high, bit 0 of the status reads 1. A done pulse clears write enable. A failure pulse leaves write enable unchanged. The packed status byte is also driven on a parallel output so that neighbours can decode the protection field. Status layout, by bit: 0 busy, 1 write enable, 4:2 protect level, 5 top/bottom select, 6 reserved (reads 0), 7 status-write lock.

Decoder states: `CMD_IDLE` (deselected), `CMD_OPCODE` (shifting in 8 opcode bits), `CMD_DATA` (shifting in the status data byte), `CMD_ARMED` (a complete command is waiting for chip select to rise), `CMD_READ` (streaming status), `CMD_SKIP` (rest of the frame discarded).

Decoder transitions:
- `CMD_IDLE` goes to `CMD_OPCODE` on select.
- From `CMD_OPCODE`, the 8th rising edge goes to `CMD_READ` for 05h, `CMD_DATA` for 01h, `CMD_ARMED` for 06h or 04h, and `CMD_SKIP` for any other opcode.
- `CMD_DATA` goes to `CMD_ARMED` on its 8th rising edge.
- `CMD_ARMED` goes to `CMD_SKIP` on any further rising edge.
- Every state returns to `CMD_IDLE` when chip select rises.

Writer states: `WR_IDLE` and `WR_BUSY`. `WR_IDLE` goes to `WR_BUSY` when a status write is accepted. `WR_BUSY` returns to `WR_IDLE` when its cycle counter expires.

Top module: `flash_status_ctl`

## Requirements
- R1: After reset the status byte is 00h. Bit 6 always reads 0. The layout is bit 0 busy, bit 1 write enable, bits 4:2 protect level, bit 5 top/bottom, bit 7 write lock.
- R2: After opcode 05h the status is driven MSB first, one bit per falling SCK edge. Bit 7 is launched on the falling edge of the 8th opcode clock.
- R3: If SCK keeps running after bit 0, the output restarts at bit 7 and repeats until chip select rises.
- R4: Opcode 05h is served while a status write or an external operation is in progress, and bit 0 then reads 1.
- R5: Opcode 06h sets write enable and 04h clears it, on the rising chip-select edge. They act only if exactly 8 clocks were received.
- R6: Opcode 01h followed by exactly one data byte starts a write on the rising chip-select edge. Only data bits 2 to 5 and bit 7 are stored. Data bits 0, 1 and 6 have no effect.
- R7: A status write with the write-protect pin low or write enable at 0 is ignored. No status bit changes, and write enable keeps its value.
- R8: A status write keeps bit 0 at 1 for exactly BUSY_CYCLES system clocks. At the end the new fields appear and write enable clears.
- R9: While busy (self-timed or external), every command other than 05h is discarded.
- R10: The external busy input is reflected in bit 0. An external done pulse clears write enable, and an external failure pulse leaves it unchanged.
- R11: Opcodes other than 05h, 01h, 06h and 04h change nothing. The data output is enabled only during a status read with chip select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | SPI serial data in |
| spi_miso | output | 1 | SPI serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| wprot_n | input | 1 | Write-protect pin; high permits status writes |
| ext_busy | input | 1 | External erase/program sequencer running |
| ext_done | input | 1 | One-cycle pulse: external write completed |
| ext_fail | input | 1 | One-cycle pulse: external write rejected or failed |
| status_o | output | 8 | Packed status byte |

## Verification
The assertions assume that SPI inputs change slowly compared with the system clock: each SCK half period spans several system clocks, so that no edge is lost in the synchronizer. They also assume that the done and failure pulses last one cycle and never coincide with a self-timed status write finishing. The bench drives every SPI line on falling system-clock edges. It holds each SCK level for four clocks, and it raises or pulses the external inputs only while no SPI frame is in flight. Every read sample is taken just before the next rising SCK edge, when the launched bit has settled.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    localparam logic [7:0] OP_RD_STATUS  = 8'h05;
    localparam logic [7:0] OP_WR_STATUS  = 8'h01;
    localparam logic [7:0] OP_SET_WEN    = 8'h06;
    localparam logic [7:0] OP_CLR_WEN    = 8'h04;

    localparam int unsigned SB_BUSY = 0;
    localparam int unsigned SB_WEN  = 1;
    localparam int unsigned SB_PL_LO = 2;
    localparam int unsigned SB_PL_HI = 4;
    localparam int unsigned SB_TOP  = 5;
    localparam int unsigned SB_LOCK = 7;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_OPCODE,
        CMD_DATA,
        CMD_ARMED,
        CMD_READ,
        CMD_SKIP
    } cmd_state_e;

    typedef enum logic {
        WR_IDLE,
        WR_BUSY
    } wr_state_e;

endpackage

// File: rtl/sr_spi_sync.sv
module sr_spi_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic sel_o,
    output logic sel_end_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic mosi_o
);

    logic cs_s, sck_s, din_s;
    logic cs_prev, sck_prev;

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_s  <= 1'b1;
                    sck_s <= 1'b0;
                    din_s <= 1'b0;
                end else begin
                    cs_s  <= cs_n_i;
                    sck_s <= sck_i;
                    din_s <= mosi_i;
                end
            end
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] cs_p, sck_p, din_p;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_p  <= '1;
                    sck_p <= '0;
                    din_p <= '0;
                end else begin
                    cs_p  <= {cs_p[SYNC_STAGES-2:0], cs_n_i};
                    sck_p <= {sck_p[SYNC_STAGES-2:0], sck_i};
                    din_p <= {din_p[SYNC_STAGES-2:0], mosi_i};
                end
            end
            assign cs_s  = cs_p[SYNC_STAGES-1];
            assign sck_s = sck_p[SYNC_STAGES-1];
            assign din_s = din_p[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    assign sel_o      = ~cs_s;
    assign sel_end_o  = cs_s & ~cs_prev;
    assign sck_rise_o = ~cs_s & sck_s & ~sck_prev;
    assign sck_fall_o = ~cs_s & ~sck_s & sck_prev;
    assign mosi_o     = din_s;

endmodule

// File: rtl/sr_cmd_fsm.sv
module sr_cmd_fsm
    import flash_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       sel_end,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi,
    input  logic [7:0] status_i,
    output logic       req_set_wen,
    output logic       req_clr_wen,
    output logic       req_write,
    output logic [7:0] wr_data,
    output logic       miso_o,
    output logic       miso_oe_o
);

    cmd_state_e state, nxt;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] opc;
    logic [7:0] data_q;
    logic [7:0] snap;
    logic [2:0] rd_idx;
    logic       miso_q;
    logic [7:0] shifted;

    assign shifted = {shreg[6:0], mosi};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CMD_IDLE:   if (sel) nxt = CMD_OPCODE;
            CMD_OPCODE: begin
                if (sel_end) nxt = CMD_IDLE;
                else if (sck_rise && bit_cnt == 3'd7) begin
                    unique case (shifted)
                        OP_RD_STATUS:             nxt = CMD_READ;
                        OP_WR_STATUS:             nxt = CMD_DATA;
                        OP_SET_WEN, OP_CLR_WEN:   nxt = CMD_ARMED;
                        default:                  nxt = CMD_SKIP;
                    endcase
                end
            end
            CMD_DATA: begin
                if (sel_end) nxt = CMD_IDLE;
                else if (sck_rise && bit_cnt == 3'd7) nxt = CMD_ARMED;
            end
            CMD_ARMED: begin
                if (sel_end) nxt = CMD_IDLE;
                else if (sck_rise) nxt = CMD_SKIP;
            end
            CMD_READ:   if (sel_end) nxt = CMD_IDLE;
            CMD_SKIP:   if (sel_end) nxt = CMD_IDLE;
            default:    nxt = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            opc     <= '0;
            data_q  <= '0;
            snap    <= '0;
            rd_idx  <= 3'd7;
            miso_q  <= 1'b0;
        end else begin
            if (state == CMD_IDLE) begin
                bit_cnt <= '0;
                rd_idx  <= 3'd7;
            end else if (sck_rise && (state == CMD_OPCODE || state == CMD_DATA)) begin
                shreg   <= shifted;
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    if (state == CMD_OPCODE) opc    <= shifted;
                    else                     data_q <= shifted;
                end
            end else if (sck_fall && state == CMD_READ) begin
                if (rd_idx == 3'd7) begin
                    snap   <= status_i;
                    miso_q <= status_i[7];
                end else begin
                    miso_q <= snap[rd_idx];
                end
                rd_idx <= rd_idx - 3'd1;
            end
        end
    end

    always_comb begin
        req_set_wen = (state == CMD_ARMED) && sel_end && (opc == OP_SET_WEN);
        req_clr_wen = (state == CMD_ARMED) && sel_end && (opc == OP_CLR_WEN);
        req_write   = (state == CMD_ARMED) && sel_end && (opc == OP_WR_STATUS);
        wr_data     = data_q;
        miso_o      = miso_q;
        miso_oe_o   = (state == CMD_READ) && sel;
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_set_wen, req_clr_wen, req_write})); // R5

    AST_REQ_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_set_wen || req_clr_wen || req_write) |-> sel_end); // R5

    AST_OE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe_o |-> sel); // R11

    AST_READ_STARTS_AT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == CMD_READ) |-> rd_idx == 3'd7); // R2

endmodule

// File: rtl/sr_status_core.sv
module sr_status_core
    import flash_sr_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_set_wen,
    input  logic       req_clr_wen,
    input  logic       req_write,
    input  logic [7:0] wr_data,
    input  logic       wprot_ok,
    input  logic       ext_busy,
    input  logic       ext_done,
    input  logic       ext_fail,
    output logic [7:0] status_o
);

    localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    wr_state_e  wr_state, wr_nxt;
    logic [CNT_W-1:0] cnt;
    logic [7:0] pend;
    logic       wen_q;
    logic [2:0] plevel_q;
    logic       top_q;
    logic       lock_q;
    logic       busy;
    logic       accept;
    logic       finish;

    assign busy   = (wr_state == WR_BUSY) || ext_busy;
    assign accept = req_write && !busy && wen_q && wprot_ok;
    assign finish = (wr_state == WR_BUSY) && (cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_state <= WR_IDLE;
        else        wr_state <= wr_nxt;
    end

    always_comb begin
        wr_nxt = wr_state;
        unique case (wr_state)
            WR_IDLE: if (accept) wr_nxt = WR_BUSY;
            WR_BUSY: if (finish) wr_nxt = WR_IDLE;
            default: wr_nxt = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            pend     <= '0;
            wen_q    <= 1'b0;
            plevel_q <= '0;
            top_q    <= 1'b0;
            lock_q   <= 1'b0;
        end else begin
            if (accept) begin
                cnt  <= CNT_LOAD;
                pend <= wr_data;
            end else if (wr_state == WR_BUSY) begin
                cnt <= cnt - CNT_LAST;
            end
            if (finish) begin
                plevel_q <= pend[SB_PL_HI:SB_PL_LO];
                top_q    <= pend[SB_TOP];
                lock_q   <= pend[SB_LOCK];
            end
            if (finish || ext_done)            wen_q <= 1'b0;
            else if (req_set_wen && !busy)     wen_q <= 1'b1;
            else if (req_clr_wen && !busy)     wen_q <= 1'b0;
        end
    end

    always_comb begin
        status_o                   = '0;
        status_o[SB_BUSY]          = busy;
        status_o[SB_WEN]           = wen_q;
        status_o[SB_PL_HI:SB_PL_LO] = plevel_q;
        status_o[SB_TOP]           = top_q;
        status_o[SB_LOCK]          = lock_q;
    end

    AST_WEN_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !status_o[SB_WEN]); // R8

    AST_BUSY_WHILE_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == WR_BUSY) |-> status_o[SB_BUSY]); // R8

    AST_FIELDS_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable({status_o[7], status_o[5:2]})); // R6

    AST_REJECT_KEEPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && wr_state == WR_IDLE && !(wprot_ok && wen_q) && !ext_done)
        |=> $stable(status_o[7:1])); // R7

    AST_FAIL_KEEPS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_fail && !ext_done && !req_set_wen && !req_clr_wen && !finish)
        |=> $stable(status_o[SB_WEN])); // R10

    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == WR_BUSY && !finish) |=> wr_state == WR_BUSY && $stable(pend)); // R9

endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl #(
    parameter int unsigned BUSY_CYCLES = 40,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    input  logic       wprot_n,
    input  logic       ext_busy,
    input  logic       ext_done,
    input  logic       ext_fail,
    output logic [7:0] status_o
);

    logic       sel, sel_end, sck_rise, sck_fall, mosi_s;
    logic       req_set_wen, req_clr_wen, req_write;
    logic [7:0] wr_data;

    sr_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (spi_cs_n),
        .sck_i      (spi_sck),
        .mosi_i     (spi_mosi),
        .sel_o      (sel),
        .sel_end_o  (sel_end),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .mosi_o     (mosi_s)
    );

    sr_cmd_fsm u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .sel_end     (sel_end),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .mosi        (mosi_s),
        .status_i    (status_o),
        .req_set_wen (req_set_wen),
        .req_clr_wen (req_clr_wen),
        .req_write   (req_write),
        .wr_data     (wr_data),
        .miso_o      (spi_miso),
        .miso_oe_o   (spi_miso_oe)
    );

    sr_status_core #(.BUSY_CYCLES(BUSY_CYCLES)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_set_wen (req_set_wen),
        .req_clr_wen (req_clr_wen),
        .req_write   (req_write),
        .wr_data     (wr_data),
        .wprot_ok    (wprot_n),
        .ext_busy    (ext_busy),
        .ext_done    (ext_done),
        .ext_fail    (ext_fail),
        .status_o    (status_o)
    );

    AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> !status_o[6]); // R1

endmodule

// File: tb/sim_flash_status_ctl.sv
`timescale 1ns/1ps
module sim_flash_status_ctl;

    localparam int BUSY = 400;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic wprot_n = 1'b1, ext_busy = 1'b0, ext_done = 1'b0, ext_fail = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic [7:0] status_o;

    int n_chk = 0;
    int n_fail = 0;
    bit quiet = 1'b0;
    bit oe_seen = 1'b0;
    bit finished = 1'b0;
    logic [7:0] m_status = 8'h00;

    always #2 clk = ~clk;

    flash_status_ctl #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .wprot_n(wprot_n), .ext_busy(ext_busy), .ext_done(ext_done),
        .ext_fail(ext_fail), .status_o(status_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && quiet) begin
            check("R1 per-clock status vs model", {24'h0, status_o}, {24'h0, m_status});
            if (spi_cs_n) check("R11 output enable idle", {31'h0, spi_miso_oe}, 32'h0);
        end
        if (spi_miso_oe) oe_seen = 1'b1;
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_run(input logic [15:0] tx, input int ntx, input int nrd,
                           output logic [31:0] rx);
        rx = '0;
        quiet = 1'b0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        clocks(HALF);
        for (int i = 0; i < ntx + nrd; i++) begin
            spi_mosi = (i < ntx) ? tx[ntx-1-i] : 1'b0;
            clocks(HALF);
            if (i >= ntx) rx = {rx[30:0], spi_miso};
            spi_sck = 1'b1;
            clocks(HALF);
            spi_sck = 1'b0;
        end
        clocks(HALF);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
    endtask

    task automatic settle();
        clocks(8);
        quiet = 1'b1;
    endtask

    task automatic cmd8(input logic [7:0] op);
        logic [31:0] rx;
        spi_run({8'h00, op}, 8, 0, rx);
    endtask

    task automatic read_check(input string tag, input int nbits, input logic [7:0] exp);
        logic [31:0] rx;
        logic [31:0] want;
        want = {exp, exp, exp, exp};
        if (nbits < 32) want = want & ((32'h1 << nbits) - 1);
        spi_run(16'h0005, 8, nbits, rx);
        check(tag, rx, want);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000; k++) begin
            if (!status_o[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rx;
        int busy_len;
        clocks(5);
        rst_n = 1'b1;
        clocks(2);
        // R1 reset state
        check("R1 reset status", {24'h0, status_o}, 32'h0);
        check("R11 reset oe", {31'h0, spi_miso_oe}, 32'h0);
        quiet = 1'b1;

        // R2 plain read
        read_check("R2 read after reset", 8, 8'h00);
        settle();

        // R5 set write enable, R3 wrap of read stream
        cmd8(8'h06); m_status = 8'h02; settle();
        read_check("R3 wrapping read", 24, 8'h02);
        settle();

        // R6/R8 accepted write, busy length
        spi_run({8'h01, 8'hFF}, 16, 0, rx);
        for (int k = 0; k < 20 && !status_o[0]; k++) @(negedge clk);
        busy_len = 0;
        while (status_o[0] && busy_len < 5000) begin
            busy_len++;
            @(negedge clk);
        end
        check("R8 busy length", busy_len, BUSY);
        check("R6 status after write FF", {24'h0, status_o}, 32'h0000_00BC);
        m_status = 8'hBC; settle();
        read_check("R2 read BC", 8, 8'hBC);
        settle();

        // R4/R9 read and discarded command while busy
        cmd8(8'h06); m_status = 8'hBE; settle();
        spi_run({8'h01, 8'h00}, 16, 0, rx);
        cmd8(8'h04);
        read_check("R4 read during busy / R9 clear discarded", 8, 8'hBF);
        wait_idle();
        clocks(2);
        check("R8 fields and enable after write 00", {24'h0, status_o}, 32'h0);
        m_status = 8'h00; settle();

        // R7 rejected writes
        spi_run({8'h01, 8'hFF}, 16, 0, rx);
        clocks(20);
        check("R7 write without enable", {24'h0, status_o}, 32'h0);
        settle();
        cmd8(8'h06); m_status = 8'h02; settle();
        wprot_n = 1'b0;
        spi_run({8'h01, 8'hFF}, 16, 0, rx);
        clocks(20);
        check("R7 write with protect pin low", {24'h0, status_o}, 32'h2);
        wprot_n = 1'b1;
        settle();

        // R5 clear enable, then malformed lengths
        cmd8(8'h04); m_status = 8'h00; settle();
        check("R5 clear enable", {24'h0, status_o}, 32'h0);
        spi_run({7'h0, 8'h06, 1'b0}, 9, 0, rx); settle();
        check("R5 nine clocks ignored", {24'h0, status_o}, 32'h0);
        spi_run(16'h0003, 7, 0, rx); settle();
        check("R5 seven clocks ignored", {24'h0, status_o}, 32'h0);

        // R6 ignored data bits 0,1,6
        cmd8(8'h06); m_status = 8'h02; settle();
        spi_run({8'h01, 8'h47}, 16, 0, rx);
        clocks(4);
        wait_idle();
        clocks(2);
        check("R6 write 47 keeps only bit2", {24'h0, status_o}, 32'h4);
        m_status = 8'h04; settle();

        // R10/R4/R9 external sequencer
        @(negedge clk); ext_busy = 1'b1; m_status = 8'h05; clocks(2);
        check("R10 external busy bit", {31'h0, status_o[0]}, 32'h1);
        read_check("R4 read during external busy", 8, 8'h05);
        cmd8(8'h06); settle();
        check("R9 enable discarded while busy", {24'h0, status_o}, 32'h5);
        @(negedge clk); ext_busy = 1'b0; m_status = 8'h04; clocks(2);
        cmd8(8'h06); m_status = 8'h06; settle();
        quiet = 1'b0;
        @(negedge clk); ext_fail = 1'b1; @(negedge clk); ext_fail = 1'b0; clocks(2);
        check("R10 failure keeps enable", {24'h0, status_o}, 32'h6);
        @(negedge clk); ext_done = 1'b1; @(negedge clk); ext_done = 1'b0; clocks(2);
        check("R10 done clears enable", {24'h0, status_o}, 32'h4);
        m_status = 8'h04; settle();

        // R11 unknown opcode
        oe_seen = 1'b0;
        spi_run(16'h009F, 8, 16, rx);
        settle();
        check("R11 no output for unknown opcode", {31'h0, oe_seen}, 32'h0);
        check("R11 status unchanged", {24'h0, status_o}, 32'h4);

        clocks(10);
        finish_run();
    end

endmodule